// File: doc/BRIEF.md
# DMA Write Packet Receiver

This block sits between a client engine that issues DMA writes and the logic that turns those writes into memory bursts. The client sends a stream of packets over one valid/ready port. A kind bit marks each packet. A command packet opens a write request and carries a start address, an atom count and an acknowledge request. The data packets that follow it each carry a 64-byte beat. The receiver forwards one record per command into a command queue. It cuts every data beat into 32-byte atoms and places them in an atom queue. Each queue has its own valid/ready output port.

Internally the block counts how many atoms of the open request are still owed. A beat that arrives when only one atom is owed gives up its lower half only, and its upper half is discarded. When nothing more is owed, the request closes and the next command is expected. Two sequencing faults are recorded in sticky error bits until software pulses a clear: a command arriving while a request is still open, and a data packet arriving with no open request. The input port stalls whenever either queue lacks room for the worst-case output of one packet.

Top module: `dma_wr_rx`

## Requirements
- R1: `in_kind` = 1 marks a command packet, which uses `in_addr`, `in_size` and `in_ack`. `in_kind` = 0 marks a data packet, which uses `in_data`. A packet is accepted on a rising edge where `in_valid` and `in_ready` are both high.
- R2: Every accepted command produces exactly one record on the command port, in acceptance order. The record carries `cmd_addr` = `in_addr`, `cmd_bytes` = (`in_size` + 1) × 32 and `cmd_ack` = `in_ack`.
- R3: An accepted data packet of an open request always emits `in_data[255:0]` as an atom. When two or more atoms are still owed, it then emits `in_data[511:256]` as the next atom. When exactly one atom is owed, the upper half is discarded.
- R4: A request closes once its full byte count has been delivered. After that, a command is accepted without any error.
- R5: A command accepted while a request is still open sets `err[0]`. The command is still forwarded, and counting restarts from its own size.
- R6: A data packet accepted with no open request sets `err[1]` and produces no atom.
- R7: Both error bits stay set until `err_clr` is high on a rising edge. If a new error is accepted on that same edge, the new error remains set.
- R8: `in_ready` is low whenever the command queue has no free entry or the atom queue has fewer than two free entries.
- R9: After reset, `in_ready` = 1, `cmd_valid` = 0, `atom_valid` = 0 and `err` = 0.
- R10: An error bit updates on the rising edge that accepts the packet causing it. A record or atom written into an empty queue becomes valid on the output one rising edge after the accepting edge.
- R11: While `cmd_valid` or `atom_valid` is high and the matching ready is low, that port holds its valid and its payload unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input packet valid |
| in_ready | output | 1 | Input packet may be accepted |
| in_kind | input | 1 | 1 = command packet, 0 = data packet |
| in_addr | input | ADDR_W | Command start address |
| in_size | input | SIZE_W | Command atom count minus one |
| in_ack | input | 1 | Command asks for an acknowledge |
| in_data | input | 2*ATOM_BYTES*8 | Data beat, low atom in the low bits |
| err_clr | input | 1 | Clears both sticky error bits |
| err | output | 2 | Bit 0: command while open; bit 1: data with no open request |
| cmd_valid | output | 1 | Command record valid |
| cmd_ready | input | 1 | Command record taken |
| cmd_addr | output | ADDR_W | Record start address |
| cmd_bytes | output | SIZE_W+1+log2(ATOM_BYTES) | Record length in bytes |
| cmd_ack | output | 1 | Record acknowledge request |
| atom_valid | output | 1 | Atom valid |
| atom_ready | input | 1 | Atom taken |
| atom_data | output | ATOM_BYTES*8 | Atom payload |

## Verification
There are two latencies. The error flags and `in_ready` react on the rising edge that accepts a packet. A queued record or atom reaches an empty output one edge after that. The bench drives inputs just after a rising edge and reads every output at the falling edge. A latency test reads the first falling edge after acceptance, where the output must still be idle, and the next falling edge, where it must be valid. Queued items are compared by a scoreboard at the falling edge before each transfer, so stalls and random sink backpressure change when an item is checked but never which item is expected.

// File: rtl/dwr_pkg.sv
package dwr_pkg;
  typedef enum logic {
    PKT_DATA = 1'b0,
    PKT_CMD  = 1'b1
  } pkt_kind_e;

  localparam int ERR_W       = 2;
  localparam int ERR_OVERLAP = 0;
  localparam int ERR_ORPHAN  = 1;
endpackage

// File: rtl/dwr_fifo.sv
// Synchronous queue with LANES write lanes per cycle and one read per cycle.
// Storage is split into LANES banks by index, so each bank sees one write.
module dwr_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  parameter int LANES = 1
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [$clog2(LANES+1)-1:0]     push_n,
  input  logic [LANES-1:0][W-1:0]        din,
  output logic [$clog2(DEPTH+1)-1:0]     free,
  output logic                           out_valid,
  output logic [W-1:0]                   out_data,
  input  logic                           out_ready
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int ROWS  = DEPTH / LANES;
  localparam int ROW_W = $clog2(ROWS);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [PTR_W-1:0] wp, rp;
  logic [CNT_W-1:0] cnt;
  logic             ld;

  logic [LANES-1:0] bank_we;
  logic [ROW_W-1:0] bank_wrow [LANES];
  logic [W-1:0]     bank_wdat [LANES];
  logic [W-1:0]     bank_rdat [LANES];
  logic [ROW_W-1:0] rd_row;
  logic [W-1:0]     rd_dat;

  // lane l goes to index wp+l; consecutive indices live in distinct banks
  always_comb begin
    for (int b = 0; b < LANES; b++) begin
      bank_we[b]   = 1'b0;
      bank_wrow[b] = '0;
      bank_wdat[b] = '0;
      for (int l = 0; l < LANES; l++) begin
        if ((l < int'(push_n)) && (((int'(wp) + l) % LANES) == b)) begin
          bank_we[b]   = 1'b1;
          bank_wrow[b] = ROW_W'(((int'(wp) + l) % DEPTH) / LANES);
          bank_wdat[b] = din[l];
        end
      end
    end
  end

  assign rd_row = ROW_W'(int'(rp) / LANES);

  for (genvar b = 0; b < LANES; b++) begin : g_bank
    logic [W-1:0] mem [ROWS];
    always_ff @(posedge clk) begin
      if (bank_we[b]) mem[bank_wrow[b]] <= bank_wdat[b];
    end
    assign bank_rdat[b] = mem[rd_row];
  end

  always_comb begin
    rd_dat = bank_rdat[0];
    for (int b = 0; b < LANES; b++) begin
      if ((int'(rp) % LANES) == b) rd_dat = bank_rdat[b];
    end
  end

  // output register refills when empty or when its item is being taken
  assign ld   = (cnt != '0) && (!out_valid || out_ready);
  assign free = CNT_W'(DEPTH) - cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      wp        <= '0;
      rp        <= '0;
      cnt       <= '0;
      out_valid <= 1'b0;
    end else begin
      wp  <= wp + PTR_W'(push_n);
      cnt <= cnt + CNT_W'(push_n) - CNT_W'(ld);
      if (ld) begin
        rp        <= rp + PTR_W'(1);
        out_valid <= 1'b1;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (ld) out_data <= rd_dat;
  end
endmodule

// File: rtl/dwr_track.sv
// Request sequencer: open flag, atoms still owed, sticky error bits.
module dwr_track
  import dwr_pkg::*;
#(
  parameter int SIZE_W = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fire,
  input  logic             is_cmd,
  input  logic [SIZE_W-1:0] size,
  input  logic             clr,
  output logic             push_cmd,
  output logic [1:0]       push_atoms,
  output logic [ERR_W-1:0] err
);
  localparam int REM_W = SIZE_W + 1;

  logic             open_q, open_n;
  logic [REM_W-1:0] rem_q, rem_n;
  logic [ERR_W-1:0] new_err;

  always_comb begin
    push_cmd   = 1'b0;
    push_atoms = 2'd0;
    new_err    = '0;
    open_n     = open_q;
    rem_n      = rem_q;
    if (fire) begin
      if (is_cmd) begin
        push_cmd             = 1'b1;
        new_err[ERR_OVERLAP] = open_q;
        open_n               = 1'b1;
        rem_n                = {1'b0, size} + REM_W'(1);
      end else if (open_q) begin
        if (rem_q >= REM_W'(2)) begin
          push_atoms = 2'd2;
          rem_n      = rem_q - REM_W'(2);
        end else begin
          push_atoms = 2'd1;
          rem_n      = rem_q - REM_W'(1);
        end
        open_n = (rem_n != '0);
      end else begin
        new_err[ERR_ORPHAN] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q <= 1'b0;
      rem_q  <= '0;
      err    <= '0;
    end else begin
      open_q <= open_n;
      rem_q  <= rem_n;
      err    <= (clr ? '0 : err) | new_err;
    end
  end
endmodule

// File: rtl/dma_wr_rx.sv
module dma_wr_rx
  import dwr_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int SIZE_W     = 13,
  parameter int ATOM_BYTES = 32,
  parameter int CMD_DEPTH  = 4,
  parameter int ATOM_DEPTH = 16
) (
  input  logic                                     clk,
  input  logic                                     rst,
  input  logic                                     in_valid,
  output logic                                     in_ready,
  input  logic                                     in_kind,
  input  logic [ADDR_W-1:0]                        in_addr,
  input  logic [SIZE_W-1:0]                        in_size,
  input  logic                                     in_ack,
  input  logic [2*ATOM_BYTES*8-1:0]                in_data,
  input  logic                                     err_clr,
  output logic [1:0]                               err,
  output logic                                     cmd_valid,
  input  logic                                     cmd_ready,
  output logic [ADDR_W-1:0]                        cmd_addr,
  output logic [SIZE_W+$clog2(ATOM_BYTES):0]       cmd_bytes,
  output logic                                     cmd_ack,
  output logic                                     atom_valid,
  input  logic                                     atom_ready,
  output logic [ATOM_BYTES*8-1:0]                  atom_data
);
  localparam int ATOM_W  = ATOM_BYTES * 8;
  localparam int ATOM_SH = $clog2(ATOM_BYTES);
  localparam int BYTES_W = SIZE_W + 1 + ATOM_SH;
  localparam int REC_W   = ADDR_W + BYTES_W + 1;
  localparam int CF_W    = $clog2(CMD_DEPTH + 1);
  localparam int AF_W    = $clog2(ATOM_DEPTH + 1);

  logic                     fire, is_cmd;
  logic                     push_cmd;
  logic [1:0]               push_atoms;
  logic [CF_W-1:0]          cmd_free;
  logic [AF_W-1:0]          atom_free;
  logic [BYTES_W-1:0]       bytes_w;
  logic [0:0][REC_W-1:0]    cmd_din;
  logic [REC_W-1:0]         cmd_rec;
  logic [1:0][ATOM_W-1:0]   atom_din;

  // room for the largest output of any one packet, whatever its kind
  assign in_ready = (cmd_free != '0) && (atom_free >= AF_W'(2));
  assign fire     = in_valid && in_ready;
  assign is_cmd   = (in_kind == PKT_CMD);

  assign bytes_w    = {{ATOM_SH{1'b0}}, ({1'b0, in_size} + (SIZE_W+1)'(1))} << ATOM_SH;
  assign cmd_din[0] = {in_addr, bytes_w, in_ack};
  assign atom_din   = in_data;

  dwr_track #(.SIZE_W(SIZE_W)) u_track (
    .clk        (clk),
    .rst        (rst),
    .fire       (fire),
    .is_cmd     (is_cmd),
    .size       (in_size),
    .clr        (err_clr),
    .push_cmd   (push_cmd),
    .push_atoms (push_atoms),
    .err        (err)
  );

  dwr_fifo #(.W(REC_W), .DEPTH(CMD_DEPTH), .LANES(1)) u_cmd_q (
    .clk       (clk),
    .rst       (rst),
    .push_n    (push_cmd),
    .din       (cmd_din),
    .free      (cmd_free),
    .out_valid (cmd_valid),
    .out_data  (cmd_rec),
    .out_ready (cmd_ready)
  );

  assign {cmd_addr, cmd_bytes, cmd_ack} = cmd_rec;

  dwr_fifo #(.W(ATOM_W), .DEPTH(ATOM_DEPTH), .LANES(2)) u_atom_q (
    .clk       (clk),
    .rst       (rst),
    .push_n    (push_atoms),
    .din       (atom_din),
    .free      (atom_free),
    .out_valid (atom_valid),
    .out_data  (atom_data),
    .out_ready (atom_ready)
  );
endmodule

// File: rtl/dma_wr_rx_chk.sv
module dma_wr_rx_chk #(
  parameter int ADDR_W     = 32,
  parameter int SIZE_W     = 13,
  parameter int ATOM_BYTES = 32
) (
  input logic                                clk,
  input logic                                rst,
  input logic                                in_valid,
  input logic                                in_ready,
  input logic                                in_kind,
  input logic                                err_clr,
  input logic [1:0]                          err,
  input logic                                cmd_valid,
  input logic                                cmd_ready,
  input logic [ADDR_W-1:0]                   cmd_addr,
  input logic [SIZE_W+$clog2(ATOM_BYTES):0]  cmd_bytes,
  input logic                                cmd_ack,
  input logic                                atom_valid,
  input logic                                atom_ready,
  input logic [ATOM_BYTES*8-1:0]             atom_data
);
  localparam int SH = $clog2(ATOM_BYTES);

  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_addr) && $stable(cmd_bytes) && $stable(cmd_ack)); // R11

  AST_ATOM_HOLD: assert property (@(posedge clk) disable iff (rst)
    atom_valid && !atom_ready |=> atom_valid && $stable(atom_data)); // R11

  AST_CMD_LEN_ATOMS: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> (cmd_bytes != '0) && (cmd_bytes[SH-1:0] == '0)); // R2

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (err != 2'b00) && !err_clr |=> ((err & $past(err)) == $past(err))); // R7

  AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (rst)
    err_clr && !(in_valid && in_ready) |=> err == 2'b00); // R7

  AST_OVERLAP_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(err[0]) |-> $past(in_valid && in_ready && in_kind)); // R5

  AST_ORPHAN_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(err[1]) |-> $past(in_valid && in_ready && !in_kind)); // R6
endmodule

bind dma_wr_rx dma_wr_rx_chk #(
  .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .ATOM_BYTES(ATOM_BYTES)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_kind(in_kind),
  .err_clr(err_clr), .err(err), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_addr(cmd_addr), .cmd_bytes(cmd_bytes), .cmd_ack(cmd_ack),
  .atom_valid(atom_valid), .atom_ready(atom_ready), .atom_data(atom_data)
);

// File: tb/dma_wr_rx_tb.sv
module dma_wr_rx_tb;
  localparam int ADDR_W  = 32;
  localparam int SIZE_W  = 13;
  localparam int ATOM_W  = 256;
  localparam int BEAT_W  = 512;
  localparam int BYTES_W = SIZE_W + 1 + 5;
  localparam int REC_W   = ADDR_W + BYTES_W + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_kind = 1'b0, in_ack = 1'b0, err_clr = 1'b0;
  logic [ADDR_W-1:0] in_addr = '0;
  logic [SIZE_W-1:0] in_size = '0;
  logic [BEAT_W-1:0] in_data = '0;
  logic cmd_ready = 1'b1, atom_ready = 1'b1;
  logic in_ready, cmd_valid, cmd_ack, atom_valid;
  logic [1:0] err;
  logic [ADDR_W-1:0] cmd_addr;
  logic [BYTES_W-1:0] cmd_bytes;
  logic [ATOM_W-1:0] atom_data;

  always #4 clk = ~clk;

  dma_wr_rx u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_kind(in_kind),
    .in_addr(in_addr), .in_size(in_size), .in_ack(in_ack), .in_data(in_data),
    .err_clr(err_clr), .err(err), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_addr(cmd_addr), .cmd_bytes(cmd_bytes), .cmd_ack(cmd_ack),
    .atom_valid(atom_valid), .atom_ready(atom_ready), .atom_data(atom_data)
  );

  int checks = 0, failures = 0;
  int sink_mode = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic [REC_W-1:0] cmd_q [$];
  logic [ATOM_W-1:0] atom_q [$];
  bit m_open = 0;
  int m_rem = 0;
  logic [1:0] m_err = 2'b00;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  function automatic logic [BEAT_W-1:0] beat(input int s);
    logic [BEAT_W-1:0] r;
    for (int i = 0; i < 16; i++) r[i*32 +: 32] = 32'(s * 16 + i) ^ 32'hA5A50000;
    return r;
  endfunction

  // sinks: 0 always ready, 1 stalled, 2 pseudo-random
  initial forever begin
    @(posedge clk); #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    cmd_ready  = (sink_mode == 0) || (sink_mode == 2 && lfsr[0]);
    atom_ready = (sink_mode == 0) || (sink_mode == 2 && lfsr[3]);
  end

  // scoreboard monitor: items on the ports at the falling edge before transfer (R2, R3)
  always @(negedge clk) begin
    if (!rst) begin
      if (cmd_valid && cmd_ready) begin
        if (cmd_q.size() == 0) chk(1'b0, "R2", "unexpected command record", cmd_addr, 0);
        else begin
          logic [REC_W-1:0] e;
          e = cmd_q.pop_front();
          chk({cmd_addr, cmd_bytes, cmd_ack} == e, "R2", "command record", {cmd_addr, cmd_bytes, cmd_ack}, e);
        end
      end
      if (atom_valid && atom_ready) begin
        if (atom_q.size() == 0) chk(1'b0, "R3", "unexpected atom", atom_data, 0);
        else begin
          logic [ATOM_W-1:0] a;
          a = atom_q.pop_front();
          chk(atom_data == a, "R3", "atom payload", atom_data, a);
        end
      end
    end
  end

  // expected behaviour for one accepted packet
  task automatic model(input bit is_cmd, input logic [ADDR_W-1:0] addr, input int size,
                       input bit ack, input logic [BEAT_W-1:0] data, input bit clr);
    logic [1:0] ne = 2'b00;
    if (is_cmd) begin
      if (m_open) ne[0] = 1'b1;
      cmd_q.push_back({addr, BYTES_W'((size + 1) * 32), ack});
      m_open = 1; m_rem = size + 1;
    end else if (m_open) begin
      atom_q.push_back(data[ATOM_W-1:0]);
      if (m_rem >= 2) begin atom_q.push_back(data[BEAT_W-1:ATOM_W]); m_rem -= 2; end
      else m_rem -= 1;
      m_open = (m_rem != 0);
    end else ne[1] = 1'b1;
    m_err = (clr ? 2'b00 : m_err) | ne;
  endtask

  task automatic send_pkt(input bit is_cmd, input logic [ADDR_W-1:0] addr, input int size,
                          input bit ack, input logic [BEAT_W-1:0] data, input bit clr);
    @(posedge clk); #1;
    in_valid = 1'b1; in_kind = is_cmd; in_addr = addr; in_size = SIZE_W'(size);
    in_ack = ack; in_data = data; err_clr = clr;
    do @(negedge clk); while (!in_ready);
    model(is_cmd, addr, size, ack, data, clr);
    @(posedge clk); #1;
    in_valid = 1'b0; err_clr = 1'b0;
  endtask

  task automatic send_req(input logic [ADDR_W-1:0] addr, input int size, input bit ack,
                          input int nbeats, input int seed);
    send_pkt(1'b1, addr, size, ack, '0, 1'b0);
    for (int i = 0; i < nbeats; i++) send_pkt(1'b0, '0, 0, 1'b0, beat(seed + i), 1'b0);
  endtask

  task automatic check_err(input string req);
    @(negedge clk);
    chk(err == m_err, req, "error bits", err, m_err);
  endtask

  task automatic wait_drain();
    int t = 0;
    while ((cmd_q.size() != 0 || atom_q.size() != 0) && t < 2000) begin @(posedge clk); t++; end
    repeat (3) @(posedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL R10 watchdog expired act=%0d exp=%0d", 100000, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    chk(in_ready == 1'b1, "R9", "in_ready after reset", in_ready, 1);
    chk(cmd_valid == 1'b0 && atom_valid == 1'b0, "R9", "outputs idle after reset", {cmd_valid, atom_valid}, 0);
    chk(err == 2'b00, "R9", "err after reset", err, 0);

    // R10 latency of a record and of an atom into empty queues; R1 kind decode
    send_pkt(1'b1, 32'h0000_1020, 0, 1'b1, '0, 1'b0);
    @(negedge clk);
    chk(cmd_valid == 1'b0, "R10", "record not yet valid after accept edge", cmd_valid, 0);
    @(negedge clk);
    chk(cmd_valid == 1'b1, "R10", "record valid one edge later", cmd_valid, 1);
    send_pkt(1'b0, '0, 0, 1'b0, beat(1), 1'b0);
    @(negedge clk);
    chk(atom_valid == 1'b0, "R10", "atom not yet valid after accept edge", atom_valid, 0);
    @(negedge clk);
    chk(atom_valid == 1'b1, "R1", "data packet produced an atom", atom_valid, 1);

    // R3 full beats, then a final half beat
    send_req(32'h0000_4000, 3, 1'b0, 2, 10);
    send_req(32'h0000_8020, 4, 1'b1, 3, 20);
    wait_drain();
    check_err("R4");

    // R6 orphan data is dropped and flagged
    send_pkt(1'b0, '0, 0, 1'b0, beat(30), 1'b0);
    check_err("R6");
    repeat (4) @(negedge clk);
    chk(atom_valid == 1'b0, "R6", "no atom from orphan data", atom_valid, 0);
    // R7 sticky, then cleared
    chk(err == 2'b10, "R7", "error held without clear", err, 2'b10);
    @(posedge clk); #1 err_clr = 1'b1;
    @(posedge clk); #1 err_clr = 1'b0;
    m_err = 2'b00;
    check_err("R7");

    // R5 command while open: flagged, forwarded, counting restarts
    send_pkt(1'b1, 32'h0001_0000, 2, 1'b0, '0, 1'b0);
    send_pkt(1'b0, '0, 0, 1'b0, beat(40), 1'b0);
    send_pkt(1'b1, 32'h0002_0040, 0, 1'b1, '0, 1'b0);
    check_err("R5");
    send_pkt(1'b0, '0, 0, 1'b0, beat(50), 1'b0);
    wait_drain();

    // R7 clear on the same edge as a new orphan error: new error wins
    send_pkt(1'b0, '0, 0, 1'b0, beat(60), 1'b1);
    check_err("R7");
    @(posedge clk); #1 err_clr = 1'b1;
    @(posedge clk); #1 err_clr = 1'b0;
    m_err = 2'b00;
    check_err("R7");

    // R8 command queue full stalls input
    sink_mode = 1;
    repeat (2) @(posedge clk);
    for (int i = 0; i < 4; i++) send_req(32'h0010_0000 + 32'(i * 64), 0, 1'b0, 1, 70 + i);
    send_pkt(1'b1, 32'h0010_1000, 0, 1'b1, '0, 1'b0);
    repeat (3) @(negedge clk);
    chk(in_ready == 1'b0, "R8", "ready low with command queue full", in_ready, 0);
    sink_mode = 0;
    send_pkt(1'b0, '0, 0, 1'b0, beat(80), 1'b0);
    wait_drain();

    // R8 atom queue short of two entries stalls input
    sink_mode = 1;
    repeat (2) @(posedge clk);
    send_req(32'h0020_0000, 17, 1'b0, 8, 100);
    repeat (3) @(negedge clk);
    chk(in_ready == 1'b0, "R8", "ready low with atom queue nearly full", in_ready, 0);
    sink_mode = 0;
    send_pkt(1'b0, '0, 0, 1'b0, beat(108), 1'b0);
    wait_drain();

    // R11 / R3 under random sink backpressure
    sink_mode = 2;
    send_req(32'h0030_0020, 20, 1'b1, 11, 200);
    send_req(32'h0031_0000, 1, 1'b0, 1, 300);
    sink_mode = 0;
    wait_drain();
    check_err("R4");

    chk(cmd_q.size() == 0, "R2", "all records delivered", cmd_q.size(), 0);
    chk(atom_q.size() == 0, "R3", "all atoms delivered", atom_q.size(), 0);
    finish_run();
  end
endmodule